// File: doc/BRIEF.md
# Two-Channel Sequential Break Sequencer

This block belongs to an on-chip debug trigger path. It takes the match strobes of two comparator channels and turns them into a break request. Each channel keeps a sticky condition-match flag. A channel can also be set up as the second half of an ordered pair. Such a channel raises a break only when the other channel has already matched and software has not cleared that match since. Either channel may lead the pair.

Channel 1 can be gated by an execution counter. When gated, a channel 1 match counts only when it brings the counter from one to zero. An ordered break is also held back unless at least two instructions have retired since the leading channel last matched. This makes the outcome inside the short window deterministic. A channel that is not the second half of a valid pair raises a break on its own match whenever its break-enable bit is set.

Top module: `seq_break_ctl`

## Requirements
- R1: Reset clears both condition flags, the break request and the execution counter. After reset, with channel 1 counting enabled and no preset loaded, a channel 1 match does not set its flag.
- R2: A channel's effective match sets its condition flag one clock later. The flag stays set until it is cleared.
- R3: A flag-clear strobe clears that channel's flag one clock later. If the channel also matches effectively in the same cycle, the flag stays set.
- R4: Ordered pair 0 then 1: channel 1 has sequential-enable 1, partner index 0 and break-enable 1. A channel 1 effective match then pulses `brk_req` in the following cycle when the channel 0 flag is set and at least two retire strobes were seen after channel 0's latest match.
- R5: Ordered pair 1 then 0 behaves the same way with the channel roles swapped: channel 0 has sequential-enable 1 and partner index 1.
- R6: A second-half match while the leading channel's flag is clear sets the second channel's flag and raises no break.
- R7: A second-half match that arrives fewer than two retires after the leading channel's latest match raises no break. Its flag is still set.
- R8: Clearing the leading channel's flag disarms the pair. A later second-half match raises no break.
- R9: A load strobe writes the preset into the channel 1 counter. Each raw channel 1 match decrements a nonzero counter. With counting enabled, channel 1 matches effectively only on the match that takes the counter from 1 to 0. A preset of 0 never matches.
- R10: A channel that is not a valid second half breaks on its own effective match when its break-enable is 1, and does not break when it is 0. A channel that is not a valid second half has sequential-enable 0, or has a partner index equal to its own number.
- R11: `brk_req` is high for one cycle for each qualifying match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| match_vld | input | 2 | Raw comparator match strobe per channel |
| retire | input | 1 | One pulse per retired instruction |
| seq_en | input | 2 | Per channel: acts as the second half of an ordered pair |
| partner_idx | input | 2 | Per channel: number of the channel that must lead |
| brk_en | input | 2 | Per channel: may raise a break |
| cnt_en | input | 1 | Gate channel 1 matches with the execution counter |
| cnt_load | input | 1 | Write strobe for the counter preset |
| cnt_preset | input | 8 | Counter preset value |
| flag_clr | input | 2 | Software clear strobe per condition flag |
| cond_flag | output | 2 | Sticky condition-match flag per channel |
| brk_req | output | 1 | Break request pulse |

## Verification
The assertions assume that configuration inputs stay fixed while a pair is in use. They also assume that at most one flag-clear strobe and one match strobe arrive per channel per cycle. The unarmed-break property assumes that the leading channel has its own break-enable cleared. The stimulus changes configuration only right after a reset and sets the leading break-enable to zero in every ordered-pair sweep. The sweeps cover both orders, gaps of zero to four retires, with and without a clear in between, and counter presets from zero to five.

// File: rtl/sbc_pkg.sv
// Shared constants and types for the sequential break sequencer.
// Assumes exactly two channels; channel indices are a single bit.
package sbc_pkg;
    localparam int NCH = 2;

    typedef struct packed {
        logic seq_en;   // channel is second half of an ordered pair
        logic partner;  // leading channel number
        logic brk_en;   // channel may raise a break
    } chan_cfg_t;
endpackage

// File: rtl/sbc_exec_count.sv
// Channel 1 execution counter. Loads a preset on a write strobe and counts
// raw matches down while nonzero. The effective match is true only on the
// 1 -> 0 transition when counting is enabled, else it follows the raw match.
// Assumes load has priority over a same-cycle match.
module sbc_exec_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    input  logic             raw_match,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             eff_match
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Counter register: load, else decrement on a match while nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= preset;
        else if (raw_match && (cnt_q != '0))
            cnt_q <= cnt_q - ONE;
    end

    // Effective match: gated by the terminal count when counting is on.
    always_comb begin
        eff_match = en ? (raw_match && (cnt_q == ONE)) : raw_match;
    end
endmodule

// File: rtl/sbc_chan.sv
// One channel's sticky condition flag plus a saturating count of retired
// instructions since the channel's latest effective match. A new match
// wins over a same-cycle clear. Assumes retire pulses once per instruction.
module sbc_chan #(
    parameter int DIST_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eff_match,
    input  logic flag_clr,
    input  logic retire,
    output logic flag_q,
    output logic gap_ok
);
    localparam int DIST_W = $clog2(DIST_MIN + 1);
    localparam logic [DIST_W-1:0] DMAX = DIST_W'(DIST_MIN);

    logic [DIST_W-1:0] dist_q;

    // Sticky flag: set by a match, cleared by software otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (eff_match)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    // Retire distance since the latest match, saturating at DIST_MIN.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dist_q <= '0;
        else if (eff_match)
            dist_q <= '0;
        else if (retire && (dist_q != DMAX))
            dist_q <= dist_q + 1'b1;
    end

    // Leading match is far enough back to honour ordering.
    always_comb begin
        gap_ok = (dist_q == DMAX);
    end
endmodule

// File: rtl/sbc_fire.sv
// Break decision. A channel that is a valid second half needs its partner
// armed (flag set) and far enough back; any other channel breaks on its own
// match. The request is registered and lasts one cycle per qualifying match.
module sbc_fire
    import sbc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  eff,
    input  logic [NCH-1:0]  flag,
    input  logic [NCH-1:0]  gap_ok,
    input  chan_cfg_t       cfg [NCH],
    output logic            brk_req
);
    logic [NCH-1:0] hit;

    for (genvar j = 0; j < NCH; j++) begin : g_hit
        localparam logic OTHER = (j == 0) ? 1'b1 : 1'b0;
        logic seq_ok;
        // Per-channel qualification of a break.
        always_comb begin
            seq_ok = cfg[j].seq_en && (cfg[j].partner == OTHER);
            if (seq_ok)
                hit[j] = eff[j] && cfg[j].brk_en
                       && flag[OTHER] && gap_ok[OTHER];
            else
                hit[j] = eff[j] && cfg[j].brk_en;
        end
    end

    // Registered break request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            brk_req <= 1'b0;
        else
            brk_req <= |hit;
    end
endmodule

// File: rtl/seq_break_ctl.sv
// Top of the two-channel sequential break sequencer. Wires the channel 1
// execution counter, two flag/distance units and the break decision.
// Assumes configuration is static while an ordered pair is in use.
module seq_break_ctl
    import sbc_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int DIST_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       match_vld,
    input  logic             retire,
    input  logic [1:0]       seq_en,
    input  logic [1:0]       partner_idx,
    input  logic [1:0]       brk_en,
    input  logic             cnt_en,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_preset,
    input  logic [1:0]       flag_clr,
    output logic [1:0]       cond_flag,
    output logic             brk_req
);
    logic [NCH-1:0]   eff_match;
    logic [NCH-1:0]   gap_ok;
    logic [CNT_W-1:0] ch1_cnt;
    logic             ch1_eff;
    chan_cfg_t        cfg [NCH];

    // Pack per-channel configuration.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cfg[i].seq_en  = seq_en[i];
            cfg[i].partner = partner_idx[i];
            cfg[i].brk_en  = brk_en[i];
        end
    end

    sbc_exec_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .preset    (cnt_preset),
        .raw_match (match_vld[1]),
        .en        (cnt_en),
        .cnt_q     (ch1_cnt),
        .eff_match (ch1_eff)
    );

    // Effective match per channel; only channel 1 has a counter.
    always_comb begin
        eff_match = {ch1_eff, match_vld[0]};
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        sbc_chan #(.DIST_MIN(DIST_MIN)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .eff_match (eff_match[c]),
            .flag_clr  (flag_clr[c]),
            .retire    (retire),
            .flag_q    (cond_flag[c]),
            .gap_ok    (gap_ok[c])
        );
    end

    sbc_fire u_fire (
        .clk     (clk),
        .rst_n   (rst_n),
        .eff     (eff_match),
        .flag    (cond_flag),
        .gap_ok  (gap_ok),
        .cfg     (cfg),
        .brk_req (brk_req)
    );
endmodule

// File: rtl/sbc_checker.sv
// Assertion checker for seq_break_ctl, attached through bind below.
module sbc_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       match_vld,
    input logic [1:0]       seq_en,
    input logic [1:0]       partner_idx,
    input logic [1:0]       brk_en,
    input logic             cnt_en,
    input logic             cnt_load,
    input logic [1:0]       flag_clr,
    input logic [CNT_W-1:0] ch1_cnt,
    input logic [1:0]       cond_flag,
    input logic             brk_req
);
    logic rst_q;

    // Track reset of the previous cycle.
    always_ff @(posedge clk) rst_q <= rst_n;

    // R1: outputs are clear right after a reset cycle.
    always_ff @(posedge clk) begin
        if (rst_q === 1'b0)
            assert_reset_clear_R1: assert (cond_flag == 2'b00 && !brk_req && ch1_cnt == '0);
    end

    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match_vld[0] |=> cond_flag[0]);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[0] && !match_vld[0]) |=> !cond_flag[0]);

    assert_brk_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(|match_vld));

    assert_no_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_en[1] && !partner_idx[1] && !seq_en[0] && !brk_en[0]
         && !cond_flag[0] && !match_vld[0]) |=> !brk_req);

    assert_count_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && ch1_cnt == '0 && !cnt_load && !cond_flag[1]) |=> !cond_flag[1]);
endmodule

bind seq_break_ctl sbc_checker #(.CNT_W(CNT_W)) u_sbc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .match_vld   (match_vld),
    .seq_en      (seq_en),
    .partner_idx (partner_idx),
    .brk_en      (brk_en),
    .cnt_en      (cnt_en),
    .cnt_load    (cnt_load),
    .flag_clr    (flag_clr),
    .ch1_cnt     (ch1_cnt),
    .cond_flag   (cond_flag),
    .brk_req     (brk_req)
);

// File: tb/seq_break_ctl_bench.sv
// Self-checking bench: sweeps order, retire gap, clear and break-enable,
// then counter presets, with expectations computed from the requirements.
module seq_break_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] match_vld;
    logic       retire;
    logic [1:0] seq_en, partner_idx, brk_en, flag_clr;
    logic       cnt_en, cnt_load;
    logic [7:0] cnt_preset;
    logic [1:0] cond_flag;
    logic       brk_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    seq_break_ctl u_seq_break_ctl (
        .clk(clk), .rst_n(rst_n), .match_vld(match_vld), .retire(retire),
        .seq_en(seq_en), .partner_idx(partner_idx), .brk_en(brk_en),
        .cnt_en(cnt_en), .cnt_load(cnt_load), .cnt_preset(cnt_preset),
        .flag_clr(flag_clr), .cond_flag(cond_flag), .brk_req(brk_req)
    );

    task automatic idle();
        match_vld = 2'b00; retire = 1'b0; flag_clr = 2'b00; cnt_load = 1'b0;
    endtask

    // Apply the current inputs for one edge; sample point is 1 ns after it.
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1;
    endtask

    initial begin
        idle();
        seq_en = 0; partner_idx = 0; brk_en = 0; cnt_en = 0; cnt_preset = 0;
        rst_n = 1'b1;
        #1;
        // Preload counter before reset so the reset clear is observable.
        cnt_load = 1'b1; cnt_preset = 8'd3; step(); idle();
        do_reset();
        chk("R1 flags", cond_flag, 0);
        chk("R1 brk", brk_req, 0);
        cnt_en = 1'b1; brk_en = 2'b10; match_vld = 2'b10; step(); idle();
        chk("R1 counter cleared", cond_flag[1], 0);
        chk("R1 no brk", brk_req, 0);
        cnt_en = 1'b0; brk_en = 2'b00;

        // R2/R3: set, same-cycle clear+match, plain clear.
        do_reset();
        match_vld = 2'b01; step(); idle();
        chk("R2 set", cond_flag[0], 1);
        step();
        chk("R2 sticky", cond_flag[0], 1);
        match_vld = 2'b01; flag_clr = 2'b01; step(); idle();
        chk("R3 match wins", cond_flag[0], 1);
        flag_clr = 2'b01; step(); idle();
        chk("R3 clear", cond_flag[0], 0);

        // R10: plain breaks and self-partner.
        do_reset();
        brk_en = 2'b01; match_vld = 2'b01; step(); idle();
        chk("R10 plain brk", brk_req, 1);
        step();
        chk("R11 pulse ends", brk_req, 0);
        brk_en = 2'b00; match_vld = 2'b01; step(); idle();
        chk("R10 brk_en off", brk_req, 0);
        do_reset();
        seq_en = 2'b10; partner_idx = 2'b10; brk_en = 2'b10;
        match_vld = 2'b10; step(); idle();
        chk("R10 self partner", brk_req, 1);

        // R4/R5/R6/R7/R8 sweep.
        for (int o = 0; o < 2; o++)
            for (int g = 0; g < 5; g++)
                for (int c = 0; c < 2; c++)
                    for (int be = 0; be < 2; be++) begin
                        int f = o;
                        int s = 1 - o;
                        int exp_brk;
                        string tag;
                        do_reset();
                        seq_en = 0; partner_idx = 0; brk_en = 0;
                        seq_en[s] = 1'b1; partner_idx[s] = f[0]; brk_en[s] = be[0];
                        match_vld[f] = 1'b1; step(); idle();
                        for (int r = 0; r < g; r++) begin
                            retire = 1'b1; step(); idle();
                        end
                        if (c == 1) begin
                            flag_clr[f] = 1'b1; step(); idle();
                        end
                        match_vld[s] = 1'b1; step(); idle();
                        exp_brk = (be == 1 && c == 0 && g >= 2) ? 1 : 0;
                        tag = (c == 1) ? "R8" : (g < 2 ? "R7" : (o == 0 ? "R4" : "R5"));
                        chk(tag, brk_req, exp_brk);
                        chk("R6 second flag", cond_flag[s], 1);
                        chk("R8 lead flag", cond_flag[f], 1 - c);
                        step();
                        chk("R11 one cycle", brk_req, 0);
                    end

        // R6: second half with no lead match at all.
        do_reset();
        seq_en = 2'b10; partner_idx = 2'b00; brk_en = 2'b10;
        for (int r = 0; r < 3; r++) begin
            retire = 1'b1; step(); idle();
        end
        match_vld = 2'b10; step(); idle();
        chk("R6 unarmed brk", brk_req, 0);
        chk("R6 flag", cond_flag[1], 1);

        // R9 counter sweep on a plain channel 1.
        for (int p = 0; p < 6; p++) begin
            do_reset();
            seq_en = 0; partner_idx = 0; brk_en = 2'b10; cnt_en = 1'b1;
            cnt_load = 1'b1; cnt_preset = 8'(p); step(); idle();
            for (int k = 1; k <= 7; k++) begin
                match_vld = 2'b10; step(); idle();
                chk("R9 flag", cond_flag[1], (p >= 1 && k >= p) ? 1 : 0);
                chk("R9 brk", brk_req, (p >= 1 && k == p) ? 1 : 0);
            end
            cnt_en = 1'b0;
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule